// File: doc/BRIEF.md
# Flash Protected Range Checker

This block sits in front of a serial flash sequencer and decides, before any flash cycle is issued, whether a request may proceed. It holds a parameterised set of range registers. Each register describes an inclusive span of 4 KiB pages and carries two independent enables: one guards reads, and one guards writes and erases. When a request arrives, its start address is compared against every range at once. One cycle later the block returns either an allow or a deny. A deny is the access-error indication that the sequencer reports in place of running the cycle.

Firmware fills the range registers through a simple write port. A lock input then freezes their contents until the next reset. The current contents of any register can be read back combinationally, so the effect of a write or of the lock can be seen at the ports.

Top module: `prot_range_chk`

## Requirements
- R1: After reset every range register reads 0, the lock is clear, and rspValid, rspAllow and rspDeny are all 0.
- R2: A request presented with reqValid high at a clock edge produces exactly one cycle of rspValid at the next edge. In that cycle exactly one of rspAllow and rspDeny is high. With reqValid low, all three outputs are low in the next cycle.
- R3: A range register has this layout: base page in bits 13:0, limit page in bits 29:16, read-protect enable in bit 15, write-protect enable in bit 31. Bits 14 and 30 read back as 0.
- R4: A range covers the byte addresses from base*4096 to limit*4096+4095, with both ends included. The page of a request is reqAddr[25:12].
- R5: A read request (reqWrite=0) is denied when its page falls inside any range that has read protection enabled.
- R6: A write or erase request (reqWrite=1) is denied when its page falls inside any range that has write protection enabled. A range with only read protection does not block it, and a range with only write protection does not block a read.
- R7: A range with both enables clear blocks nothing. A range whose base is above its limit blocks nothing.
- R8: Ranges are checked in parallel. A hit in any one range, including the highest-numbered one, denies the request.
- R9: A write with cfgIdx at or above NUM_RANGES changes no register, and reading such an index returns 0.
- R10: From the cycle in which lockIn is first seen high, all register writes are ignored until reset, even after lockIn falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockIn | input | 1 | Freezes the range registers until reset |
| cfgWe | input | 1 | Range register write strobe |
| cfgIdx | input | IDXW | Range register select for write and readback |
| cfgWdata | input | 32 | Range register write data |
| cfgRdata | output | 32 | Contents of the selected register; 0 for an unused index |
| reqValid | input | 1 | Access check request |
| reqWrite | input | 1 | 1 for write or erase, 0 for read |
| reqAddr | input | 26 | Start byte address of the request |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspAllow | output | 1 | Request may proceed |
| rspDeny | output | 1 | Access error: the request hits a protected range |

## Verification
The hardest situation to reach is a lock that takes effect in the same cycle as an attempted write, and then stays in force after lockIn has fallen. The stimulus programs a write-protected range, raises lockIn together with a write that would clear that range, drops lockIn, and writes again. Each time it checks both the readback and a write request into the old range, which must still be denied. The page boundaries are driven at the first byte of the base page, the last byte of the limit page, and one byte outside each end.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int PAGE_W   = 14;
  localparam int ADDR_W   = PAGE_W + 12;
  localparam int BASE_LSB = 0;
  localparam int LIM_LSB  = 16;
  localparam int RD_BIT   = 15;
  localparam int WR_BIT   = 31;
  localparam logic [31:0] KEEP_MASK = 32'hBFFF_BFFF;

  typedef struct packed {
    logic regWr;
    logic capture;
    logic isWrite;
  } prc_strobe_t;
endpackage

// File: rtl/prc_ctrl.sv
module prc_ctrl import prc_pkg::*; #(
  parameter int NUM_RANGES = 5,
  parameter int IDXW = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lockIn,
  input  logic            cfgWe,
  input  logic [IDXW-1:0] cfgIdx,
  input  logic            reqValid,
  input  logic            reqWrite,
  output prc_strobe_t     strobe,
  output logic            locked
);
  logic lockQ;

  always_ff @(posedge clk) begin
    if (!rstN) lockQ <= 1'b0;
    else if (lockIn) lockQ <= 1'b1;
  end

  assign locked = lockQ | lockIn;

  always_comb begin
    strobe.regWr   = cfgWe && !locked && (int'(cfgIdx) < NUM_RANGES);
    strobe.capture = reqValid;
    strobe.isWrite = reqWrite;
  end

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);
endmodule

// File: rtl/prc_dpath.sv
module prc_dpath import prc_pkg::*; #(
  parameter int NUM_RANGES = 5,
  parameter int IDXW = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  prc_strobe_t       strobe,
  input  logic              locked,
  input  logic [IDXW-1:0]   cfgIdx,
  input  logic [31:0]       cfgWdata,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [31:0]       cfgRdata,
  output logic              rspValid,
  output logic              rspAllow,
  output logic              rspDeny
);
  logic [NUM_RANGES-1:0][31:0] rangeQ;
  logic [NUM_RANGES-1:0]       rdHit, wrHit, anyEn;
  logic [PAGE_W-1:0]           reqPage;
  logic                        denyNow;

  assign reqPage = reqAddr[ADDR_W-1:12];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeQ <= '0;
    end else if (strobe.regWr) begin
      for (int i = 0; i < NUM_RANGES; i++)
        if (int'(cfgIdx) == i) rangeQ[i] <= cfgWdata & KEEP_MASK;
    end
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
    logic [PAGE_W-1:0] basePg, limPg;
    logic              inSpan;
    assign basePg   = rangeQ[g][BASE_LSB +: PAGE_W];
    assign limPg    = rangeQ[g][LIM_LSB +: PAGE_W];
    assign inSpan   = (reqPage >= basePg) && (reqPage <= limPg);
    assign rdHit[g] = inSpan && rangeQ[g][RD_BIT];
    assign wrHit[g] = inSpan && rangeQ[g][WR_BIT];
    assign anyEn[g] = rangeQ[g][RD_BIT] | rangeQ[g][WR_BIT];
  end

  assign denyNow = strobe.isWrite ? (|wrHit) : (|rdHit);

  always_comb begin
    cfgRdata = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (int'(cfgIdx) == i) cfgRdata = rangeQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAllow <= 1'b0;
      rspDeny  <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      rspAllow <= strobe.capture && !denyNow;
      rspDeny  <= strobe.capture && denyNow;
    end
  end

  // R2
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAllow != rspDeny));
  // R7
  deny_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDeny |-> $past(|anyEn));
  // R10
  lock_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(rangeQ));
endmodule

// File: rtl/prot_range_chk.sv
module prot_range_chk import prc_pkg::*; #(
  parameter int NUM_RANGES = 5,
  parameter int IDXW = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockIn,
  input  logic              cfgWe,
  input  logic [IDXW-1:0]   cfgIdx,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspAllow,
  output logic              rspDeny
);
  prc_strobe_t strobe;
  logic        locked;

  prc_ctrl #(.NUM_RANGES(NUM_RANGES), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .reqValid(reqValid), .reqWrite(reqWrite), .strobe(strobe), .locked(locked)
  );

  prc_dpath #(.NUM_RANGES(NUM_RANGES), .IDXW(IDXW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .locked(locked), .cfgIdx(cfgIdx),
    .cfgWdata(cfgWdata), .reqAddr(reqAddr), .cfgRdata(cfgRdata),
    .rspValid(rspValid), .rspAllow(rspAllow), .rspDeny(rspDeny)
  );

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: tb/sim_prot_range_chk.sv
module sim_prot_range_chk;
  localparam int NUM = 5;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockIn = 1'b0, cfgWe = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [IW-1:0] cfgIdx = '0;
  logic [31:0] cfgWdata = '0, cfgRdata;
  logic [25:0] reqAddr = '0;
  logic rspValid, rspAllow, rspDeny;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] refRegs [NUM];
  bit refLock = 0;

  always #2 clk = ~clk;

  prot_range_chk #(.NUM_RANGES(NUM)) u0 (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspAllow(rspAllow), .rspDeny(rspDeny)
  );

  function automatic bit refDeny(logic [25:0] a, bit w);
    int pg = int'(a) / 4096;
    bit d = 0;
    for (int i = 0; i < NUM; i++) begin
      int b = int'(refRegs[i] & 32'h3FFF);
      int l = int'((refRegs[i] >> 16) & 32'h3FFF);
      bit en = w ? refRegs[i][31] : refRegs[i][15];
      if (en && pg >= b && pg <= l) d = 1;
    end
    return d;
  endfunction

  function automatic logic [31:0] refRead(int idx);
    return (idx < NUM) ? refRegs[idx] : 32'h0;
  endfunction

  task automatic step(string tag, bit we, int idx, logic [31:0] wd, bit lk,
                      bit rv, bit rw, logic [25:0] addr);
    bit eV, eA, eD;
    logic [31:0] eR;
    @(negedge clk);
    cfgWe = we; cfgIdx = IW'(idx); cfgWdata = wd; lockIn = lk;
    reqValid = rv; reqWrite = rw; reqAddr = addr;
    eV = rv; eD = rv && refDeny(addr, rw); eA = rv && !eD;
    if (we && !lk && !refLock && idx < NUM) refRegs[idx] = wd & 32'hBFFF_BFFF;
    if (lk) refLock = 1;
    eR = refRead(idx);
    @(posedge clk); #1;
    checks++;
    if ({rspValid, rspAllow, rspDeny} !== {eV, eA, eD} || cfgRdata !== eR) begin
      failures++;
      $display("FAIL %s: got v/a/d=%b%b%b rd=%h expected %b%b%b rd=%h",
               tag, rspValid, rspAllow, rspDeny, cfgRdata, eV, eA, eD, eR);
    end
  endtask

  task automatic rq(string tag, bit w, logic [25:0] a);
    step(tag, 0, 0, 0, 0, 1, w, a);
  endtask

  task automatic wr(string tag, int idx, logic [31:0] d);
    step(tag, 1, idx, d, 0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM; i++) refRegs[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++; // R1
    if ({rspValid, rspAllow, rspDeny} !== 3'b000 || cfgRdata !== 0) begin
      failures++;
      $display("FAIL R1: got %b%b%b %h expected 000 0", rspValid, rspAllow, rspDeny, cfgRdata);
    end
    @(negedge clk); rstN = 1;
    step("R1", 0, 3, 0, 0, 0, 0, 0);
    rq("R2", 0, 26'h0000000);
    rq("R2", 1, 26'h3FFFFFF);
    step("R2", 0, 0, 0, 0, 0, 1, 26'h10000);
    // range0: write protect pages 0x10..0x12
    wr("R3", 0, 32'h8012_0010);
    rq("R6", 1, 26'h0010000);
    rq("R4", 1, 26'h0012FFF);
    rq("R4", 1, 26'h0013000);
    rq("R4", 1, 26'h000FFFF);
    rq("R6", 0, 26'h0011000);
    // range1: read protect page 0x100 only
    wr("R3", 1, 32'h0100_8100);
    rq("R5", 0, 26'h0100000);
    rq("R5", 0, 26'h0100FFF);
    rq("R6", 1, 26'h0100800);
    rq("R5", 0, 26'h0101000);
    // range2 inactive spanning everything
    wr("R7", 2, 32'h3FFF_0000);
    rq("R7", 0, 26'h0200000);
    rq("R7", 1, 26'h0200000);
    // range3 base above limit
    wr("R7", 3, 32'h8020_8030);
    rq("R7", 1, 26'h0025000);
    rq("R7", 0, 26'h0030000);
    // range4 highest index, both kinds
    wr("R8", 4, 32'h8300_82FF);
    rq("R8", 0, 26'h2FF000);
    rq("R8", 1, 26'h300ABC);
    rq("R8", 1, 26'h301000);
    // mask of unused bits
    wr("R3", 2, 32'hFFFF_FFFF);
    step("R3", 0, 2, 0, 0, 0, 0, 0);
    rq("R3", 1, 26'h3FF0000);
    wr("R3", 2, 32'h0);
    // out-of-range index
    wr("R9", 5, 32'h8000_3FFF);
    wr("R9", 7, 32'h8000_3FFF);
    step("R9", 0, 7, 0, 0, 0, 0, 0);
    rq("R9", 1, 26'h0200000);
    // lock in same cycle as a clearing write
    step("R10", 1, 0, 32'h0, 1, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 1, 1, 26'h0011000);
    wr("R10", 0, 32'h0);
    wr("R10", 1, 32'h8FFF_0000);
    step("R10", 0, 1, 0, 0, 1, 0, 26'h0100000);
    rq("R10", 1, 26'h0012000);
    rq("R10", 1, 26'h1000000);
    // reset clears the lock and registers
    @(negedge clk); rstN = 0;
    for (int i = 0; i < NUM; i++) refRegs[i] = 0;
    refLock = 0;
    cfgWe = 0; reqValid = 0; lockIn = 0;
    @(negedge clk); rstN = 1;
    step("R1", 0, 0, 0, 0, 1, 1, 26'h0011000);
    wr("R1", 0, 32'h8001_0001);
    rq("R1", 1, 26'h0001000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule